// File: doc/BRIEF.md
# PLL Retune Sequencer

This block is a hardware state machine that moves a clock PLL to new settings without ever feeding the core clock from a PLL that is changing or not yet locked. A single request supplies the reference divider, the feedback multiplier, the power-of-two output divider, the post-divider setting, a reference-source choice, a forced-bypass flag, a flag saying whether the divider set is usable, and the reference and target rates. The block then drives the PLL control word and the post-divider word through a fixed sequence. First it takes the core clock off the PLL. Then it chooses the reference source and puts the PLL in bypass. It loads the dividers, releases bypass, and waits a settle interval counted on a slow timer. After that it polls lock and finally hands the core clock back.

When the target rate is close to the reference rate, the block does not tune the PLL. It also skips tuning when the request is marked unusable, when the output divider code is zero, or when bypass is forced. In each of these cases it leaves the dividers unchanged, runs the PLL in bypass and reselects it. If lock does not arrive within a bounded number of cycles, the block flags an error, returns the PLL to bypass and reselects it. The lock input and the slow tick both come from other clock domains, and each passes through a two-flop synchronizer. The `busy` output is high while a sequence runs. The `done` output pulses once when the PLL select is raised again.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset the outputs are: `busy`=0, `done`=0, `lock_err`=0, `sel_pll`=0, `sel_ref`=0, `pll_bypass`=1. Bits 30:0 of `ctl_word` read 0x00040400 (divider fields 0, output divider code 1, bypass set). `outdiv_word` reads 0x100.
- R2: `ctl_word` packs the fields as follows: reference divider in bits 2:0, multiplier in bits 9:4, output divider code in bits 11:10, PLL select in bit 16, reference select in bit 17, bypass in bit 18, and the synchronized lock flag in bit 31. All other bits are 0. `outdiv_word` holds the post-divider value in bits 5:0 and the post-divider-off flag in bit 8.
- R3: In the first cycle after a request is accepted, `sel_pll` is 0 and `busy` is 1. `sel_pll` stays 0 for as long as `busy` is 1.
- R4: On the tuning path, bypass is set and then the divider fields are loaded. Bypass is released only after the load. The divider fields and `outdiv_word` never change in a cycle where bypass reads 0.
- R5: After bypass is released, lock is ignored until five rising edges of the synchronized slow tick have been seen. This means the timer must move past the start value plus four ticks.
- R6: After the settle wait, the block stays busy until the synchronized lock reads 1. It then sets `sel_pll`, and `done` is high for exactly that one cycle.
- R7: The request takes the bypass path when the target rate lies inside the inclusive window from 0.75× to 1.25× the reference (4·rate ≥ 3·ref and 4·rate ≤ 5·ref), or when `req_force_bypass` is 1. On this path the divider fields stay unchanged, bypass is 1 and `sel_pll` returns to 1.
- R8: A request with `req_cfg_valid`=0, or with an output divider code of 0, falls back to the bypass path. The divider fields are not loaded, and the output divider field never reads 0.
- R9: A request that arrives while `busy` is 1 has no effect on any output.
- R10: If lock has not arrived after `LOCK_TIMEOUT` polling cycles, `lock_err` goes to 1, bypass returns to 1, and `sel_pll` is set with a `done` pulse. The next accepted request clears `lock_err`.
- R11: `sel_ref` takes the value of the request's `req_refsel` before any divider is loaded, and keeps it until the next request.
- R12: A request presented in the same cycle that `done` is high is accepted and runs a complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_r | input | 3 | Reference divider code |
| req_f | input | 6 | Feedback multiplier code |
| req_q | input | 2 | Output power-of-two divider code (0 is illegal) |
| req_div | input | 6 | Post-divider value |
| req_div_off | input | 1 | 1 disables the post-divider |
| req_refsel | input | 1 | Reference source choice for the PLL input |
| req_force_bypass | input | 1 | Force the bypass path |
| req_cfg_valid | input | 1 | Divider set is usable |
| req_ref_hz | input | RATE_W | Reference rate |
| req_rate_hz | input | RATE_W | Target rate |
| pll_lock_in | input | 1 | Asynchronous lock flag from the PLL |
| slow_tick_in | input | 1 | Asynchronous slow timer tick |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when PLL select is raised again |
| lock_err | output | 1 | Lock timeout occurred in the last sequence |
| sel_pll | output | 1 | Core clock taken from PLL |
| sel_ref | output | 1 | PLL reference source select |
| pll_bypass | output | 1 | PLL internal bypass |
| ctl_word | output | 32 | Packed PLL control word |
| outdiv_word | output | 9 | Packed post-divider word |

## Verification
Two events can land in the same cycle: the `done` pulse that ends one sequence and a new request that starts the next. The bench sets up this collision by watching for `done` and presenting a forced-bypass request in that very cycle. It judges the result by requiring a second `done` whose control word carries the second request's reference select and bypass, while the divider fields from the first sequence are kept. A request sent during the settle wait must leave no trace in the scoreboard's next comparison.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int R_W      = 3;
    localparam int F_W      = 6;
    localparam int Q_W      = 2;
    localparam int D_W      = 6;
    localparam int CTL_W    = 32;
    localparam int OUTDIV_W = 9;

    localparam int R_LSB      = 0;
    localparam int F_LSB      = 4;
    localparam int Q_LSB      = 10;
    localparam int SEL_BIT    = 16;
    localparam int REFSEL_BIT = 17;
    localparam int BYP_BIT    = 18;
    localparam int LOCK_BIT   = 31;
    localparam int DOFF_BIT   = 8;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [F_W-1:0] f;
        logic [Q_W-1:0] q;
    } pll_div_t;

    typedef struct packed {
        logic [D_W-1:0] div;
        logic           off;
    } post_div_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REF,
        S_PROG,
        S_UNBYP,
        S_SETTLE,
        S_POLL,
        S_FIN
    } seq_state_t;

    localparam pll_div_t  RST_DIV  = '{r: '0, f: '0, q: Q_W'(1)};
    localparam post_div_t RST_POST = '{div: '0, off: 1'b1};

    function automatic logic [CTL_W-1:0] pack_ctl(pll_div_t d, logic sel,
                                                  logic refsel, logic byp,
                                                  logic lock);
        logic [CTL_W-1:0] w;
        w = '0;
        w[R_LSB +: R_W] = d.r;
        w[F_LSB +: F_W] = d.f;
        w[Q_LSB +: Q_W] = d.q;
        w[SEL_BIT]      = sel;
        w[REFSEL_BIT]   = refsel;
        w[BYP_BIT]      = byp;
        w[LOCK_BIT]     = lock;
        return w;
    endfunction

    function automatic logic [OUTDIV_W-1:0] pack_outdiv(post_div_t p);
        logic [OUTDIV_W-1:0] w;
        w = '0;
        w[D_W-1:0] = p.div;
        w[DOFF_BIT] = p.off;
        return w;
    endfunction

    function automatic logic cfg_usable(pll_div_t d, logic valid);
        return valid && (d.q != '0);
    endfunction

endpackage

// File: rtl/pll_sync2.sv
module pll_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pll_ref_window.sv
module pll_ref_window #(
    parameter int RATE_W = 32
) (
    input  logic [RATE_W-1:0] ref_hz,
    input  logic [RATE_W-1:0] rate_hz,
    output logic              near
);
    localparam int XW = RATE_W + 3;

    logic [XW-1:0] ref_x, rate_x4, lo_lim, hi_lim;

    always_comb begin
        ref_x   = {3'b000, ref_hz};
        rate_x4 = {3'b000, rate_hz} << 2;
        lo_lim  = ref_x + (ref_x << 1);
        hi_lim  = ref_x + (ref_x << 2);
        near    = (rate_x4 >= lo_lim) && (rate_x4 <= hi_lim);
    end
endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
    parameter int SETTLE_TICKS = 4,
    parameter bit TIMEOUT_EN   = 1'b1,
    parameter int TIMEOUT_CYC  = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic settle_en,
    input  logic tick_rise,
    input  logic poll_en,
    output logic settle_done,
    output logic timed_out
);
    localparam int TW = $clog2(SETTLE_TICKS + 2);
    localparam int WW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tick_cnt <= '0;
        end else if (settle_en && tick_rise && (tick_cnt != TW'(SETTLE_TICKS))) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    assign settle_done = settle_en && tick_rise && (tick_cnt == TW'(SETTLE_TICKS));

    generate
        if (TIMEOUT_EN) begin : g_timeout
            logic [WW-1:0] wait_cnt;
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    wait_cnt <= '0;
                end else if (poll_en && (wait_cnt != WW'(TIMEOUT_CYC - 1))) begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
            assign timed_out = poll_en && (wait_cnt == WW'(TIMEOUT_CYC - 1));
        end else begin : g_no_timeout
            assign timed_out = poll_en & 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_seq_pkg::*;
#(
    parameter int RATE_W       = 32,
    parameter int SETTLE_TICKS = 4,
    parameter bit TIMEOUT_EN   = 1'b1,
    parameter int LOCK_TIMEOUT = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [R_W-1:0]      req_r,
    input  logic [F_W-1:0]      req_f,
    input  logic [Q_W-1:0]      req_q,
    input  logic [D_W-1:0]      req_div,
    input  logic                req_div_off,
    input  logic                req_refsel,
    input  logic                req_force_bypass,
    input  logic                req_cfg_valid,
    input  logic [RATE_W-1:0]   req_ref_hz,
    input  logic [RATE_W-1:0]   req_rate_hz,
    input  logic                pll_lock_in,
    input  logic                slow_tick_in,
    output logic                busy,
    output logic                done,
    output logic                lock_err,
    output logic                sel_pll,
    output logic                sel_ref,
    output logic                pll_bypass,
    output logic [CTL_W-1:0]    ctl_word,
    output logic [OUTDIV_W-1:0] outdiv_word
);
    seq_state_t state;

    pll_div_t          lat_div, cur_div;
    post_div_t         lat_post, cur_post;
    logic              lat_refsel, lat_force, lat_cfg;
    logic [RATE_W-1:0] lat_ref, lat_rate;

    logic sel_q, ref_q, byp_q, done_q, err_q;

    logic lock_s, tick_s, tick_d, tick_rise;
    logic near_ref, take_bypass;
    logic settle_done, timed_out;

    pll_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pll_lock_in, slow_tick_in}),
        .q   ({lock_s, tick_s})
    );

    always_ff @(posedge clk) begin
        if (rst) tick_d <= 1'b0;
        else     tick_d <= tick_s;
    end
    assign tick_rise = tick_s && !tick_d;

    pll_ref_window #(.RATE_W(RATE_W)) u_window (
        .ref_hz  (lat_ref),
        .rate_hz (lat_rate),
        .near    (near_ref)
    );

    pll_wait_timer #(
        .SETTLE_TICKS (SETTLE_TICKS),
        .TIMEOUT_EN   (TIMEOUT_EN),
        .TIMEOUT_CYC  (LOCK_TIMEOUT)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .clear       (state == S_UNBYP),
        .settle_en   (state == S_SETTLE),
        .tick_rise   (tick_rise),
        .poll_en     (state == S_POLL),
        .settle_done (settle_done),
        .timed_out   (timed_out)
    );

    assign take_bypass = lat_force || near_ref || !cfg_usable(lat_div, lat_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            lat_div    <= RST_DIV;
            lat_post   <= RST_POST;
            lat_refsel <= 1'b0;
            lat_force  <= 1'b0;
            lat_cfg    <= 1'b0;
            lat_ref    <= '0;
            lat_rate   <= '0;
            cur_div    <= RST_DIV;
            cur_post   <= RST_POST;
            sel_q      <= 1'b0;
            ref_q      <= 1'b0;
            byp_q      <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        lat_div    <= '{r: req_r, f: req_f, q: req_q};
                        lat_post   <= '{div: req_div, off: req_div_off};
                        lat_refsel <= req_refsel;
                        lat_force  <= req_force_bypass;
                        lat_cfg    <= req_cfg_valid;
                        lat_ref    <= req_ref_hz;
                        lat_rate   <= req_rate_hz;
                        sel_q      <= 1'b0;
                        err_q      <= 1'b0;
                        state      <= S_REF;
                    end
                end
                S_REF: begin
                    ref_q <= lat_refsel;
                    byp_q <= 1'b1;
                    state <= take_bypass ? S_FIN : S_PROG;
                end
                S_PROG: begin
                    cur_div  <= lat_div;
                    cur_post <= lat_post;
                    state    <= S_UNBYP;
                end
                S_UNBYP: begin
                    byp_q <= 1'b0;
                    state <= S_SETTLE;
                end
                S_SETTLE: begin
                    if (settle_done) state <= S_POLL;
                end
                S_POLL: begin
                    if (lock_s) begin
                        state <= S_FIN;
                    end else if (timed_out) begin
                        byp_q <= 1'b1;
                        err_q <= 1'b1;
                        state <= S_FIN;
                    end
                end
                S_FIN: begin
                    sel_q  <= 1'b1;
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy        = (state != S_IDLE);
    assign done        = done_q;
    assign lock_err    = err_q;
    assign sel_pll     = sel_q;
    assign sel_ref     = ref_q;
    assign pll_bypass  = byp_q;
    assign ctl_word    = pack_ctl(cur_div, sel_q, ref_q, byp_q, lock_s);
    assign outdiv_word = pack_outdiv(cur_post);

endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        lock_err,
    input logic        sel_pll,
    input logic        pll_bypass,
    input logic [31:0] ctl_word,
    input logic [8:0]  outdiv_word
);
    p_sel_off_busy_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sel_pll);

    p_fields_held_unbypassed_r4: assert property (@(posedge clk) disable iff (rst)
        !pll_bypass |-> ($stable(ctl_word[11:0]) && $stable(outdiv_word)));

    p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_with_sel_rise_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel_pll && !$past(sel_pll)));

    p_sel_after_lock_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(sel_pll) && !pll_bypass) |-> $past(ctl_word[31], 2));

    p_q_legal_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_word[11:10] != 2'b00);

    p_err_in_bypass_r10: assert property (@(posedge clk) disable iff (rst)
        lock_err |-> pll_bypass);
endmodule

bind pll_retune_seq pll_retune_seq_chk u_chk (.*);

// File: tb/pll_retune_seq_tb.sv
module pll_retune_seq_tb;
    localparam int TO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_r = '0;
    logic [5:0]  req_f = '0;
    logic [1:0]  req_q = '0;
    logic [5:0]  req_div = '0;
    logic        req_div_off = 1'b0;
    logic        req_refsel = 1'b0;
    logic        req_force_bypass = 1'b0;
    logic        req_cfg_valid = 1'b0;
    logic [31:0] req_ref_hz = '0;
    logic [31:0] req_rate_hz = '0;
    logic        pll_lock_in = 1'b0;
    logic        slow_tick_in = 1'b0;
    logic        busy, done, lock_err, sel_pll, sel_ref, pll_bypass;
    logic [31:0] ctl_word;
    logic [8:0]  outdiv_word;

    always #5 clk = ~clk;

    pll_retune_seq #(.LOCK_TIMEOUT(TO)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_r(req_r),
        .req_f(req_f), .req_q(req_q), .req_div(req_div),
        .req_div_off(req_div_off), .req_refsel(req_refsel),
        .req_force_bypass(req_force_bypass), .req_cfg_valid(req_cfg_valid),
        .req_ref_hz(req_ref_hz), .req_rate_hz(req_rate_hz),
        .pll_lock_in(pll_lock_in), .slow_tick_in(slow_tick_in),
        .busy(busy), .done(done), .lock_err(lock_err), .sel_pll(sel_pll),
        .sel_ref(sel_ref), .pll_bypass(pll_bypass), .ctl_word(ctl_word),
        .outdiv_word(outdiv_word)
    );

    typedef struct packed {
        logic [30:0] ctl;
        logic [8:0]  od;
        logic        err;
    } exp_t;

    exp_t q_exp[$];
    int n_checks = 0;
    int n_bad = 0;
    int n_done = 0;

    // model of the last loaded divider settings
    logic [2:0] m_r = 3'd0;
    logic [5:0] m_f = 6'd0;
    logic [1:0] m_q = 2'd1;
    logic [5:0] m_d = 6'd0;
    logic       m_off = 1'b1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    // send a request; when accept is set, push the expected end state
    task automatic send(input logic [2:0] r, input logic [5:0] f, input logic [1:0] q,
                        input logic [5:0] d, input logic off, input logic refsel,
                        input logic force_b, input logic cfg, input logic [31:0] refhz,
                        input logic [31:0] rate, input bit will_lock, input bit accept);
        exp_t e;
        logic [63:0] r4, lo, hi;
        bit byp_path, near;
        logic byp, err;
        r4 = 64'(rate) * 4;
        lo = 64'(refhz) * 3;
        hi = 64'(refhz) * 5;
        near = (r4 >= lo) && (r4 <= hi);
        byp_path = force_b || near || !cfg || (q == 2'd0);
        if (accept) begin
            if (!byp_path) begin
                m_r = r; m_f = f; m_q = q; m_d = d; m_off = off;
                byp = !will_lock;
                err = !will_lock;
            end else begin
                byp = 1'b1;
                err = 1'b0;
            end
            e.ctl = {12'b0, byp, refsel, 1'b1, 4'b0, m_q, m_f, 1'b0, m_r};
            e.od  = {m_off, 2'b00, m_d};
            e.err = err;
            q_exp.push_back(e);
        end
        req_r = r; req_f = f; req_q = q; req_div = d; req_div_off = off;
        req_refsel = refsel; req_force_bypass = force_b; req_cfg_valid = cfg;
        req_ref_hz = refhz; req_rate_hz = rate; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick_in = 1'b1;
            repeat (3) @(negedge clk);
            slow_tick_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic wait_done(input int target, input int maxc, input string tag);
        for (int i = 0; i < maxc && n_done < target; i++) @(negedge clk);
        check(tag, 64'(n_done >= target), 64'd1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            n_done++;
            if (q_exp.size() == 0) begin
                check("R9 unexpected done", 64'd1, 64'd0);
            end else begin
                e = q_exp.pop_front();
                check("R2 R4 R7 R8 ctl_word", 64'(ctl_word[30:0]), 64'(e.ctl));
                check("R2 outdiv_word", 64'(outdiv_word), 64'(e.od));
                check("R10 lock_err at done", 64'(lock_err), 64'(e.err));
                check("R6 sel_pll at done", 64'(sel_pll), 64'd1);
            end
        end
    end

    initial begin
        #2_000_000;
        check("watchdog expired", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        int t;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 lock_err", 64'(lock_err), 64'd0);
        check("R1 sel_pll", 64'(sel_pll), 64'd0);
        check("R1 sel_ref", 64'(sel_ref), 64'd0);
        check("R1 bypass", 64'(pll_bypass), 64'd1);
        check("R1 ctl_word", 64'(ctl_word[30:0]), 64'h0004_0400);
        check("R1 outdiv_word", 64'(outdiv_word), 64'h100);

        // R7 lower edge of the window, R11 refsel taken
        t = n_done;
        send(3'd1, 6'd31, 2'd2, 6'd5, 1'b0, 1'b1, 1'b0, 1'b1, 1000, 750, 1'b1, 1'b1);
        wait_done(t + 1, 20, "R7 lower window done");
        check("R11 sel_ref", 64'(sel_ref), 64'd1);

        // R7 upper edge of the window
        t = n_done;
        send(3'd2, 6'd10, 2'd1, 6'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1000, 1250, 1'b1, 1'b1);
        wait_done(t + 1, 20, "R7 upper window done");

        // tuning path, lock present from the start
        pll_lock_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 lock flag bit31", 64'(ctl_word[31]), 64'd1);
        t = n_done;
        send(3'd3, 6'd31, 2'd2, 6'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1000, 749, 1'b1, 1'b1);
        check("R3 sel cleared", 64'(sel_pll), 64'd0);
        check("R3 busy", 64'(busy), 64'd1);
        repeat (4) @(negedge clk);
        check("R4 fields loaded", 64'(ctl_word[11:0]), 64'({2'd2, 6'd31, 1'b0, 3'd3}));
        check("R4 bypass released", 64'(pll_bypass), 64'd0);
        check("R11 sel_ref before load", 64'(sel_ref), 64'd1);
        pulse_ticks(4);
        // R9 request while busy must change nothing
        send(3'd7, 6'd1, 2'd1, 6'd9, 1'b1, 1'b0, 1'b1, 1'b1, 1000, 1000, 1'b1, 1'b0);
        repeat (6) @(negedge clk);
        check("R5 still busy after four ticks", 64'(busy), 64'd1);
        check("R5 no select after four ticks", 64'(sel_pll), 64'd0);
        check("R5 no done yet", 64'(n_done), 64'(t));
        slow_tick_in = 1'b1;
        wait_done(t + 1, 40, "R6 done after fifth tick");
        slow_tick_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 done is one pulse", 64'(done), 64'd0);

        // R10 lock timeout
        pll_lock_in = 1'b0;
        repeat (4) @(negedge clk);
        t = n_done;
        send(3'd0, 6'd47, 2'd3, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1000, 3000, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        pulse_ticks(4);
        slow_tick_in = 1'b1;
        wait_done(t + 1, 300, "R10 timeout done");
        slow_tick_in = 1'b0;
        check("R10 lock_err set", 64'(lock_err), 64'd1);
        check("R10 bypass after timeout", 64'(pll_bypass), 64'd1);
        repeat (4) @(negedge clk);

        // R8 zero output divider code
        t = n_done;
        send(3'd4, 6'd20, 2'd0, 6'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1000, 4000, 1'b1, 1'b1);
        wait_done(t + 1, 20, "R8 q zero done");
        check("R10 lock_err cleared", 64'(lock_err), 64'd0);

        // R8 unusable configuration
        t = n_done;
        send(3'd5, 6'd12, 2'd2, 6'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1000, 4000, 1'b1, 1'b1);
        wait_done(t + 1, 20, "R8 invalid config done");

        // R7 forced bypass
        t = n_done;
        send(3'd6, 6'd40, 2'd3, 6'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1000, 8000, 1'b1, 1'b1);
        wait_done(t + 1, 20, "R7 forced bypass done");

        // R12 request in the done cycle
        pll_lock_in = 1'b1;
        repeat (4) @(negedge clk);
        t = n_done;
        send(3'd2, 6'd20, 2'd1, 6'd3, 1'b0, 1'b0, 1'b0, 1'b1, 500, 2000, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        pulse_ticks(4);
        slow_tick_in = 1'b1;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        check("R12 first done seen", 64'(done), 64'd1);
        send(3'd1, 6'd9, 2'd2, 6'd8, 1'b1, 1'b1, 1'b1, 1'b1, 500, 5000, 1'b1, 1'b1);
        slow_tick_in = 1'b0;
        wait_done(t + 2, 30, "R12 second sequence done");
        check("R12 sel_ref from second request", 64'(sel_ref), 64'd1);

        repeat (5) @(negedge clk);
        check("R9 scoreboard drained", 64'(q_exp.size()), 64'd0);
        finish_run();
    end
endmodule